// File: doc/BRIEF.md
# I2C Bus Slave with Host-Paced Clock Hold

This block is an I2C target that answers to one programmable address, 7-bit or 10-bit. It connects to the two open-drain bus wires through sampled inputs (`scl_i`, `sda_i`) and drive-low enables (`scl_low_o`, `sda_low_o`). A host on the other side sees four 16-bit registers. It programs the address and the mode through them, supplies the bytes the bus master reads, and collects the bytes the master writes.

Incoming bits gather in a shift register. A finished byte moves into a separate holding buffer and raises a one-cycle interrupt, so the next byte can already be arriving while the host reads the last one. When the hold option is on, the slave clears its release bit after every matched address or accepted byte. It then keeps SCL low after the acknowledge clock until the host writes the release bit back to 1. This lets software pace the bus one byte at a time.

Register indices on `reg_addr`:
- 0: control. Bit 0 is release, bit 1 selects 10-bit mode, bit 2 enables the hold.
- 1: slave address, in bits 9:0.
- 2: data. A write loads the transmit byte; a read returns the receive buffer.
- 3: status.

Top module: `i2c_hold_slave`

## Requirements
- R1: After reset both drive-low enables are 0 and the control and status registers read 0.
- R2: In 7-bit mode (control bit 1 = 0), a first byte after START whose bits 7:1 equal address bits 6:0 is acknowledged by pulling SDA low during the ninth clock. Any other first byte is not acknowledged, and the rest of the transfer is ignored.
- R3: In 10-bit mode, a first byte `11110`, address bits 9:8, `0` is acknowledged, and so is a second byte equal to address bits 7:0. After a repeated START, a first byte `11110`, address bits 9:8, `1` is acknowledged and starts a read. A mismatch in either byte is not acknowledged.
- R4: A data byte written by the master is acknowledged, is readable at register 2, and sets status bit 0. A host read of register 2 clears status bit 0.
- R5: Each hand-off into the receive buffer raises `irq_o` for exactly one clock cycle.
- R6: A byte that completes while status bit 0 is set is not acknowledged, leaves the buffer unchanged and sets status bit 6. Writing 0 to bit 6 clears it.
- R7: On a read addressed to it, the slave shifts the register-2 transmit byte out MSB first, once for each byte the master requests. A master NACK sets status bit 3 and releases SDA.
- R8: With control bit 2 set, a matched address or an accepted byte clears control bit 0. The slave then holds SCL low from the falling edge of the acknowledge clock until the host writes control bit 0 as 1. Status bit 5 shows the hold.
- R9: A START resets the bit count in the middle of a byte. A STOP releases both lines and clears status bits 1, 2, 4 and 5.
- R10: Host writes to status bits 5:0 have no effect. Bit 6 follows the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL wire |
| sda_i | input | 1 | Sampled SDA wire |
| scl_low_o | output | 1 | Pull SCL low (clock hold) |
| sda_low_o | output | 1 | Pull SDA low (ACK or transmit zero) |
| reg_addr | input | 2 | Host register index |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (clears receive-full on index 2) |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data, combinational from `reg_addr` |
| irq_o | output | 1 | Byte-received interrupt pulse |

## Verification
Each bus edge passes through two synchronizer flops and one engine register. An SDA drive change therefore follows the SCL falling edge that causes it by three clocks. The bench master holds every SCL phase for eight clocks, so it always samples SDA at least five clocks after the slave has moved it. Status, buffer and interrupt updates land on the same edge that sees the eighth rising SCL edge, which falls well inside the master's following low phase. The bench reads these registers only after the ACK clock or after STOP. Hold checks wait tens of clocks after the acknowledge clock before they look at `scl_low_o` and the bus line.

// File: rtl/i2c_hold_pkg.sv
package i2c_hold_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADR1,
      ST_ADR2,
      ST_RX,
      ST_TX
   } slv_state_e;

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_ADDR = 2'd1;
   localparam logic [1:0] REG_DATA = 2'd2;
   localparam logic [1:0] REG_STAT = 2'd3;

   localparam int STAT_OVF_BIT = 6;
   localparam logic [4:0] WIDE_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_prev, sda_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_prev <= scl_pipe[STAGES-1];
         sda_prev <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_prev;
   assign scl_fall  = ~scl_s & scl_prev;
   assign start_evt = scl_s & scl_prev & sda_prev & ~sda_s;
   assign stop_evt  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match import i2c_hold_pkg::*; #(
   parameter int ADDR_BITS  = 10,
   parameter int BYTE_W     = 8,
   parameter bit ALLOW_WIDE = 1'b1
) (
   input  logic [BYTE_W-1:0]    byte_in,
   input  logic [ADDR_BITS-1:0] slave_addr,
   input  logic                 wide,
   input  logic                 wide_seen,
   output logic                 hit7,
   output logic                 hit_hi_w,
   output logic                 hit_hi_r,
   output logic                 hit_lo
);
   generate
      if (ADDR_BITS != 10 || BYTE_W != 8) begin : g_bad_geom
         $error("i2c_addr_match expects a 10-bit address and 8-bit bytes");
      end
   endgenerate

   logic use_wide;
   assign hit7 = ~use_wide && (byte_in[7:1] == slave_addr[6:0]);

   generate
      if (ALLOW_WIDE) begin : g_wide
         logic hi_ok;
         assign use_wide = wide;
         assign hi_ok    = (byte_in[7:3] == WIDE_PREFIX) && (byte_in[2:1] == slave_addr[9:8]);
         assign hit_hi_w = wide && hi_ok && !byte_in[0];
         assign hit_hi_r = wide && hi_ok && byte_in[0] && wide_seen;
         assign hit_lo   = wide && (byte_in == slave_addr[7:0]);
      end else begin : g_narrow
         assign use_wide = 1'b0;
         assign hit_hi_w = 1'b0;
         assign hit_hi_r = 1'b0;
         assign hit_lo   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/i2c_hold_regs.sv
module i2c_hold_regs import i2c_hold_pkg::*; #(
   parameter int REG_W     = 16,
   parameter int ADDR_BITS = 10,
   parameter int BYTE_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           reg_addr,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   input  logic                 rx_load,
   input  logic [BYTE_W-1:0]    rx_byte,
   input  logic                 ovf_set,
   input  logic                 rel_clr,
   input  logic                 st_dir,
   input  logic                 st_sel,
   input  logic                 st_mnack,
   input  logic                 st_busy,
   input  logic                 st_hold,
   output logic                 ctrl_rel,
   output logic                 ctrl_wide,
   output logic                 ctrl_stretch,
   output logic [ADDR_BITS-1:0] slave_addr,
   output logic [BYTE_W-1:0]    tx_byte,
   output logic                 tx_wr,
   output logic                 rx_full,
   output logic                 ovf,
   output logic [BYTE_W-1:0]    rx_buf,
   output logic                 irq
);
   generate
      if (REG_W < ADDR_BITS || REG_W < STAT_OVF_BIT + 1) begin : g_bad_width
         $error("i2c_hold_regs register width too small");
      end
   endgenerate

   logic wr_ctrl, wr_addr, wr_data, wr_stat, rd_data;
   assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
   assign wr_addr = reg_wr && (reg_addr == REG_ADDR);
   assign wr_data = reg_wr && (reg_addr == REG_DATA);
   assign wr_stat = reg_wr && (reg_addr == REG_STAT);
   assign rd_data = reg_rd && (reg_addr == REG_DATA);
   assign tx_wr   = wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_rel     <= 1'b0;
         ctrl_wide    <= 1'b0;
         ctrl_stretch <= 1'b0;
         slave_addr   <= '0;
         tx_byte      <= '0;
         rx_full      <= 1'b0;
         ovf          <= 1'b0;
         rx_buf       <= '0;
         irq          <= 1'b0;
      end else begin
         irq <= rx_load;
         if (wr_ctrl) begin
            ctrl_rel     <= reg_wdata[0];
            ctrl_wide    <= reg_wdata[1];
            ctrl_stretch <= reg_wdata[2];
         end else if (rel_clr) begin
            ctrl_rel <= 1'b0;
         end
         if (wr_addr) slave_addr <= reg_wdata[ADDR_BITS-1:0];
         if (wr_data) tx_byte <= reg_wdata[BYTE_W-1:0];
         if (rx_load) begin
            rx_buf  <= rx_byte;
            rx_full <= 1'b1;
         end else if (rd_data) begin
            rx_full <= 1'b0;
         end
         if (ovf_set)      ovf <= 1'b1;
         else if (wr_stat) ovf <= reg_wdata[STAT_OVF_BIT];
      end
   end

   always_comb begin
      case (reg_addr)
         REG_CTRL: reg_rdata = REG_W'({ctrl_stretch, ctrl_wide, ctrl_rel});
         REG_ADDR: reg_rdata = REG_W'(slave_addr);
         REG_DATA: reg_rdata = REG_W'(rx_buf);
         default:  reg_rdata = REG_W'({ovf, st_hold, st_busy, st_mnack, st_sel, st_dir, rx_full});
      endcase
   end
endmodule

// File: rtl/i2c_hold_slave.sv
module i2c_hold_slave import i2c_hold_pkg::*; #(
   parameter int SYNC_STAGES = 2,
   parameter int REG_W       = 16,
   parameter bit ALLOW_WIDE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             scl_low_o,
   output logic             sda_low_o,
   input  logic [1:0]       reg_addr,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             irq_o
);
   localparam int ADDR_BITS = 10;
   localparam int BYTE_W    = 8;
   localparam int CNT_W     = $clog2(BYTE_W + 2);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

   logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
   logic ctrl_rel, ctrl_wide, ctrl_stretch, tx_wr, rx_full, ovf;
   logic [ADDR_BITS-1:0] slave_addr;
   logic [BYTE_W-1:0]    tx_byte, rx_buf;
   logic hit7, hit_hi_w, hit_hi_r, hit_lo;

   slv_state_e           st, dec_state;
   logic [CNT_W-1:0]     cnt;
   logic [BYTE_W-1:0]    sr, tx_sr, byte_in;
   logic ack_pend, ack_low, tx_phase, hold, rw, sel, mnack, busy, wide_seen, m_ack;
   logic dec_ack, dec_sel, dec_rw, dec_m10, dec_take;
   logic byte_done, rx_load, ovf_set, rel_clr;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt)
   );

   assign byte_in = {sr[BYTE_W-2:0], sda_s};

   i2c_addr_match #(.ADDR_BITS(ADDR_BITS), .BYTE_W(BYTE_W), .ALLOW_WIDE(ALLOW_WIDE)) u_match (
      .byte_in(byte_in), .slave_addr(slave_addr), .wide(ctrl_wide), .wide_seen(wide_seen),
      .hit7(hit7), .hit_hi_w(hit_hi_w), .hit_hi_r(hit_hi_r), .hit_lo(hit_lo)
   );

   always_comb begin
      dec_ack   = 1'b0;
      dec_state = st;
      dec_sel   = sel;
      dec_rw    = rw;
      dec_m10   = wide_seen;
      dec_take  = 1'b0;
      case (st)
         ST_ADR1: begin
            if (hit7) begin
               dec_ack   = 1'b1;
               dec_sel   = 1'b1;
               dec_rw    = byte_in[0];
               dec_state = byte_in[0] ? ST_TX : ST_RX;
               dec_take  = 1'b1;
            end else if (hit_hi_w) begin
               dec_ack   = 1'b1;
               dec_state = ST_ADR2;
            end else if (hit_hi_r) begin
               dec_ack   = 1'b1;
               dec_sel   = 1'b1;
               dec_rw    = 1'b1;
               dec_state = ST_TX;
               dec_take  = 1'b1;
            end else begin
               dec_state = ST_IDLE;
               dec_m10   = 1'b0;
            end
         end
         ST_ADR2: begin
            if (hit_lo) begin
               dec_ack   = 1'b1;
               dec_sel   = 1'b1;
               dec_rw    = 1'b0;
               dec_m10   = 1'b1;
               dec_state = ST_RX;
               dec_take  = 1'b1;
            end else begin
               dec_state = ST_IDLE;
               dec_m10   = 1'b0;
            end
         end
         ST_RX: begin
            if (!rx_full) begin
               dec_ack  = 1'b1;
               dec_take = 1'b1;
            end
         end
         default: ;
      endcase
   end

   assign byte_done = scl_rise && (cnt == LAST_BIT) && !start_evt && !stop_evt;
   assign rx_load   = byte_done && (st == ST_RX) && !rx_full;
   assign ovf_set   = byte_done && (st == ST_RX) && rx_full;
   assign rel_clr   = byte_done && dec_take && ctrl_stretch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         sr        <= '0;
         tx_sr     <= '0;
         ack_pend  <= 1'b0;
         ack_low   <= 1'b0;
         tx_phase  <= 1'b0;
         hold      <= 1'b0;
         rw        <= 1'b0;
         sel       <= 1'b0;
         mnack     <= 1'b0;
         busy      <= 1'b0;
         wide_seen <= 1'b0;
         m_ack     <= 1'b0;
      end else if (stop_evt) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         ack_pend  <= 1'b0;
         ack_low   <= 1'b0;
         tx_phase  <= 1'b0;
         hold      <= 1'b0;
         rw        <= 1'b0;
         sel       <= 1'b0;
         busy      <= 1'b0;
         wide_seen <= 1'b0;
      end else if (start_evt) begin
         st       <= ST_ADR1;
         cnt      <= '0;
         ack_pend <= 1'b0;
         ack_low  <= 1'b0;
         tx_phase <= 1'b0;
         hold     <= 1'b0;
         sel      <= 1'b0;
         mnack    <= 1'b0;
         busy     <= 1'b1;
      end else begin
         if (hold && ctrl_rel) hold <= 1'b0;
         if (tx_wr && hold && st == ST_TX) tx_sr <= reg_wdata[BYTE_W-1:0];
         if (scl_rise) begin
            if (cnt < ACK_SLOT) sr <= byte_in;
            if (cnt == ACK_SLOT) m_ack <= ~sda_s;
            if (cnt != ACK_DONE) cnt <= cnt + 1'b1;
            if (byte_done) begin
               ack_pend  <= dec_ack;
               st        <= dec_state;
               sel       <= dec_sel;
               rw        <= dec_rw;
               wide_seen <= dec_m10;
            end
         end
         if (scl_fall) begin
            if (cnt == ACK_SLOT) begin
               ack_low  <= ack_pend;
               tx_phase <= 1'b0;
            end else if (cnt == ACK_DONE) begin
               ack_low  <= 1'b0;
               ack_pend <= 1'b0;
               cnt      <= '0;
               if (ack_low && ctrl_stretch && !ctrl_rel) hold <= 1'b1;
               if (st == ST_TX) begin
                  if (ack_low || m_ack) begin
                     tx_sr    <= tx_byte;
                     tx_phase <= 1'b1;
                  end else begin
                     tx_phase <= 1'b0;
                     mnack    <= 1'b1;
                     st       <= ST_IDLE;
                  end
               end
            end else if (tx_phase && cnt != '0) begin
               tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign scl_low_o = hold;
   assign sda_low_o = ack_low | (tx_phase & ~tx_sr[BYTE_W-1]);

   i2c_hold_regs #(.REG_W(REG_W), .ADDR_BITS(ADDR_BITS), .BYTE_W(BYTE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_load(rx_load), .rx_byte(byte_in), .ovf_set(ovf_set), .rel_clr(rel_clr),
      .st_dir(rw), .st_sel(sel), .st_mnack(mnack), .st_busy(busy), .st_hold(hold),
      .ctrl_rel(ctrl_rel), .ctrl_wide(ctrl_wide), .ctrl_stretch(ctrl_stretch),
      .slave_addr(slave_addr), .tx_byte(tx_byte), .tx_wr(tx_wr),
      .rx_full(rx_full), .ovf(ovf), .rx_buf(rx_buf), .irq(irq_o)
   );
endmodule

// File: rtl/i2c_hold_slave_chk.sv
module i2c_hold_slave_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_o,
   input logic              scl_low_o,
   input logic              sda_low_o,
   input logic              rx_full,
   input logic              ovf,
   input logic [BYTE_W-1:0] rx_buf,
   input logic              ctrl_rel,
   input logic              stop_evt
);
   // R5: interrupt is a single-cycle pulse
   p_irq_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   // R4: an interrupt coincides with a full receive buffer
   p_irq_with_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> rx_full);

   // R6: raising overflow leaves the buffer untouched
   p_no_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $stable(rx_buf));

   // R8: a host release ends the clock hold on the next cycle
   p_release_ends_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_low_o && ctrl_rel) |=> !scl_low_o);

   // R9: STOP frees both lines
   p_stop_frees_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> (!scl_low_o && !sda_low_o));
endmodule

bind i2c_hold_slave i2c_hold_slave_chk #(.BYTE_W(8)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
   .rx_full(rx_full), .ovf(ovf), .rx_buf(rx_buf), .ctrl_rel(ctrl_rel), .stop_evt(stop_evt)
);

// File: tb/i2c_hold_slave_test.sv
module i2c_hold_slave_test;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic scl_low_o, sda_low_o, irq_o;
   logic scl_bus, sda_bus;

   int n_chk = 0, n_fail = 0, irq_cnt = 0, irq_bad = 0;
   logic irq_prev = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign scl_bus = ~(m_scl_low | scl_low_o);
   assign sda_bus = ~(m_sda_low | sda_low_o);

   i2c_hold_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   always @(negedge clk) begin
      if (irq_o) irq_cnt++;
      if (irq_o && irq_prev) irq_bad++;
      irq_prev <= irq_o;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic hwait(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_scl_high();
      while (!scl_bus) @(negedge clk);
   endtask

   task automatic host_wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic host_rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      m_sda_low = ~b;
      hwait(HALF);
      m_scl_low = 1'b0;
      wait_scl_high();
      hwait(HALF);
      m_scl_low = 1'b1;
   endtask

   task automatic recv_bit(output logic b);
      m_sda_low = 1'b0;
      hwait(HALF);
      m_scl_low = 1'b0;
      wait_scl_high();
      hwait(HALF / 2);
      b = sda_bus;
      hwait(HALF / 2);
      m_scl_low = 1'b1;
   endtask

   task automatic bus_start();
      m_sda_low = 1'b0;
      hwait(HALF);
      m_scl_low = 1'b0;
      wait_scl_high();
      hwait(HALF);
      m_sda_low = 1'b1;
      hwait(HALF);
      m_scl_low = 1'b1;
      hwait(HALF);
   endtask

   task automatic bus_stop();
      m_sda_low = 1'b1;
      hwait(HALF);
      m_scl_low = 1'b0;
      wait_scl_high();
      hwait(HALF);
      m_sda_low = 1'b0;
      hwait(HALF);
   endtask

   task automatic wr_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic rd_byte(output logic [7:0] d, input logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(~ack);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] rd;
      logic        ack;
      logic [7:0]  d1, d2;
      int          irq_base;

      hwait(5);
      rst_n = 1'b1;
      hwait(3);

      // R1: reset state
      chk("R1 scl drive", scl_low_o, 0);
      chk("R1 sda drive", sda_low_o, 0);
      host_rd(2'd0, rd); chk("R1 ctrl", rd, 0);
      host_rd(2'd3, rd); chk("R1 stat", rd, 0);

      host_wr(2'd1, 16'h005A);

      // R2: sweep every 7-bit address
      for (int a = 0; a < 128; a++) begin
         bus_start();
         wr_byte({a[6:0], 1'b0}, ack);
         chk($sformatf("R2 ack addr %02h", a), ack, (a == 'h5A));
         bus_stop();
      end

      // R4, R5: data bytes into the buffer
      for (int v = 0; v < 16; v++) begin
         logic [7:0] dv;
         dv = 8'((v * 8'h11) ^ 8'h0F);
         irq_base = irq_cnt;
         bus_start();
         wr_byte(8'hB4, ack);
         wr_byte(dv, ack);
         chk("R4 data ack", ack, 1);
         bus_stop();
         chk("R5 one irq per byte", irq_cnt - irq_base, 1);
         host_rd(2'd3, rd); chk("R4 full set", rd, 16'h0001);
         host_rd(2'd2, rd); chk("R4 buffer value", rd, {8'h00, dv});
         host_rd(2'd3, rd); chk("R4 full cleared", rd, 16'h0000);
      end
      chk("R5 no wide irq", irq_bad, 0);

      // R6, R10: overflow
      irq_base = irq_cnt;
      bus_start();
      wr_byte(8'hB4, ack);
      wr_byte(8'h11, ack);
      wr_byte(8'h22, ack);
      chk("R6 overflow nack", ack, 0);
      bus_stop();
      chk("R5 irq only for accepted", irq_cnt - irq_base, 1);
      host_rd(2'd3, rd); chk("R6 overflow flag", rd, 16'h0041);
      host_wr(2'd3, 16'h003E);
      host_rd(2'd3, rd); chk("R10 low bits read-only, R6 clear", rd, 16'h0001);
      host_rd(2'd2, rd); chk("R6 buffer kept", rd, 16'h0011);

      // R7: transmit
      for (int v = 0; v < 8; v++) begin
         logic [7:0] tv;
         tv = 8'(v * 37 + 3);
         host_wr(2'd2, {8'h00, tv});
         bus_start();
         wr_byte(8'hB5, ack);
         chk("R7 read addr ack", ack, 1);
         rd_byte(d1, 1'b1);
         rd_byte(d2, 1'b0);
         chk("R7 first byte", d1, tv);
         chk("R7 second byte", d2, tv);
         hwait(4);
         chk("R7 sda released", sda_low_o, 0);
         host_rd(2'd3, rd); chk("R7 nack status", rd, 16'h001E);
         bus_stop();
      end

      // R3: 10-bit addressing, address 0x2B7
      host_wr(2'd0, 16'h0002);
      host_wr(2'd1, 16'h02B7);
      bus_start();
      wr_byte(8'hF4, ack); chk("R3 high byte ack", ack, 1);
      wr_byte(8'hB7, ack); chk("R3 low byte ack", ack, 1);
      wr_byte(8'h5E, ack); chk("R3 data ack", ack, 1);
      bus_stop();
      host_rd(2'd2, rd); chk("R3 data stored", rd, 16'h005E);
      bus_start();
      wr_byte(8'hF4, ack);
      wr_byte(8'hB6, ack); chk("R3 low byte mismatch", ack, 0);
      bus_stop();
      bus_start();
      wr_byte(8'hF2, ack); chk("R3 high byte mismatch", ack, 0);
      bus_stop();
      host_wr(2'd2, 16'h00C9);
      bus_start();
      wr_byte(8'hF4, ack);
      wr_byte(8'hB7, ack);
      bus_start();
      wr_byte(8'hF5, ack); chk("R3 read after restart ack", ack, 1);
      rd_byte(d1, 1'b0);
      chk("R3 read data", d1, 8'hC9);
      bus_stop();

      // R9: START in the middle of a byte
      host_wr(2'd0, 16'h0000);
      host_wr(2'd1, 16'h005A);
      bus_start();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      bus_start();
      wr_byte(8'hB4, ack); chk("R9 restart resets count", ack, 1);
      bus_stop();

      // R8: host-paced hold
      host_wr(2'd0, 16'h0005);
      irq_base = irq_cnt;
      bus_start();
      wr_byte(8'hB4, ack); chk("R8 addr ack", ack, 1);
      hwait(40);
      chk("R8 hold after address", scl_low_o, 1);
      host_rd(2'd0, rd); chk("R8 release bit cleared", rd, 16'h0004);
      fork
         wr_byte(8'h77, ack);
         begin
            hwait(60);
            chk("R8 bus clock held", scl_bus, 0);
            host_wr(2'd0, 16'h0005);
         end
      join
      chk("R8 data ack", ack, 1);
      hwait(40);
      chk("R8 hold after data", scl_low_o, 1);
      host_rd(2'd3, rd); chk("R8 hold status", rd, 16'h0035);
      host_rd(2'd2, rd); chk("R8 data value", rd, 16'h0077);
      host_wr(2'd0, 16'h0005);
      hwait(2);
      chk("R8 released", scl_low_o, 0);
      bus_stop();
      hwait(4);
      chk("R9 scl free after stop", scl_low_o, 0);
      chk("R9 sda free after stop", sda_low_o, 0);
      host_rd(2'd3, rd); chk("R9 status after stop", rd, 16'h0000);
      chk("R5 irq in hold test", irq_cnt - irq_base, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule